// File: doc/BRIEF.md
# Ethernet MAC control and stop sequencer

This block is the control front end of a small Ethernet MAC. A host reaches it over a simple single-cycle register bus. It keeps a control register that holds a run (out-of-local-reset) bit, a MAC enable bit and a graceful transmit stop request. It also keeps a DMA configuration word, a sticky event register and an interrupt mask. A window of the address space is passed through to an external descriptor/filter table, and that window is cut off while the MAC sits in local reset.

From the control state it drives permission and strobe signals to abstract transmit, receive, DMA and FIFO engines. It follows frame-in-progress through start/end pulses from those engines. The block has two ways to stop. A graceful stop withholds new transmit starts, waits for the frame in flight to finish, and then posts a completion event. Disabling the MAC aborts at once: it issues abort strobes and a pointer reset, marks the cut transmit frame with a bad-CRC strobe, and blocks descriptor write-back.

Top module: `emac_ctl_seq`

## Requirements
- R1: After hardware reset the control register (offset 0; bit 0 run, bit 1 enable, bit 2 graceful stop) reads 0. Bits 15..3 always read 0 and writes to them have no effect.
- R2: While run is 0 (local reset), enable and graceful stop read 0 whatever value is written. The DMA word (offset 1), event (offset 2) and mask (offset 3) read 0 and ignore writes, and `mac_run` is low.
- R3: `rx_en` is high exactly when run and enable are both 1. `tx_go` is high when run and enable are 1 and graceful stop is 0.
- R4: With graceful stop set, the event bit (offset 2, bit 0) is not set while a transmit frame is in progress. It is set two cycles after the `tx_eof` pulse, or two cycles after the request if transmit is idle, and it is set only once per assertion of the request.
- R5: The event bit stays set until the host writes 1 to offset 2 bit 0. `irq` equals the event bit AND the mask bit (offset 3, bit 0).
- R6: In the cycle after enable falls, `ptr_rst` pulses for one cycle. `tx_abort` and `rx_abort` pulse in that same cycle only if the matching frame is in progress, and `rx_en` is already low.
- R7: `tx_bad_crc` pulses for one cycle, one cycle after `tx_abort`, only when the abort came from clearing enable with run still 1. A local-reset abort or a disable with no frame in flight gives no pulse.
- R8: `tx_wb_go` follows `tx_wb_req` only while run and enable are both 1. It is low from the abort cycle on.
- R9: A write to the DMA word is stored only while enable is 0. A write while enable is 1 is acknowledged but leaves the previous value.
- R10: Accesses to offsets 4..7 get no acknowledge and return 0.
- R11: Offsets 8..15 go to the table (`tbl_sel` high, read data from `tbl_rdata`) when run is 1. In local reset `tbl_sel` stays low and the access is acknowledged with data 0.
- R12: Clearing graceful stop while enabled raises `tx_go` again and re-arms the event, so a later request posts it anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| hb_sel | input | 1 | Host access strobe, one cycle per access |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_addr | input | 4 | Word offset |
| hb_wdata | input | 16 | Write data |
| hb_ack | output | 1 | Same-cycle acknowledge |
| hb_rdata | output | 16 | Read data, valid with acknowledge |
| tbl_sel | output | 1 | Forwarded table access strobe |
| tbl_we | output | 1 | Table write enable |
| tbl_addr | output | 3 | Table word index |
| tbl_wdata | output | 16 | Table write data |
| tbl_rdata | input | 16 | Table read data |
| mac_run | output | 1 | Datapath out of local reset |
| tx_go | output | 1 | Transmit engine may start a new frame |
| rx_en | output | 1 | Receive engine enable |
| tx_sof | input | 1 | Transmit frame started (pulse) |
| tx_eof | input | 1 | Transmit frame finished (pulse) |
| rx_sof | input | 1 | Receive frame started (pulse) |
| rx_eof | input | 1 | Receive frame finished (pulse) |
| tx_abort | output | 1 | Abort the transmit frame in flight |
| rx_abort | output | 1 | Abort the receive frame in flight |
| ptr_rst | output | 1 | Reset DMA, descriptor and FIFO pointers |
| tx_bad_crc | output | 1 | Emit a corrupted FCS for the aborted frame |
| tx_wb_req | input | 1 | DMA asks to write back transmit descriptor status |
| tx_wb_go | output | 1 | Write-back permitted |
| dma_cfg | output | 16 | DMA configuration word |
| irq | output | 1 | Interrupt request |

## Verification
The in-RTL assertions watch, every cycle, that the DMA word never moves while the MAC was enabled, that the gated registers stay clear through local reset, that abort and pointer-reset strobes are single pulses tied to the fall of enable, and that a bad-CRC strobe or write-back permit never appears while transmission is allowed or disabled respectively. The bench scenarios show what depends on the order of events: graceful stop waiting for a frame's end, the one-shot and re-arm of the completion event, the write-one-to-clear path to the interrupt, and the difference between an enable-clear abort and a local-reset abort. They also cover the address map: the reserved hole, the blocked table window and the dropped DMA write.

// File: rtl/emac_ctl_pkg.sv
package emac_ctl_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 4;

  // Control register bit positions
  localparam int unsigned CB_RUN = 0;
  localparam int unsigned CB_EN  = 1;
  localparam int unsigned CB_GTS = 2;
  localparam int unsigned CB_NUM = 3;

  // Register word offsets inside the lower half of the map
  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_DMA  = 1;
  localparam int unsigned OFF_EVT  = 2;
  localparam int unsigned OFF_MASK = 3;
  localparam int unsigned NUM_REGS = 4;

  typedef enum logic [2:0] {
    RG_CTRL,
    RG_DMA,
    RG_EVT,
    RG_MASK,
    RG_TBL,
    RG_NONE
  } reg_sel_e;

endpackage

// File: rtl/emac_rst_sync.sv
module emac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  // Assert asynchronously, release after STAGES clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/emac_host_regs.sv
module emac_host_regs
  import emac_ctl_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_sel,
  input  logic          hb_wr,
  input  logic [AW-1:0] hb_addr,
  input  logic [DW-1:0] hb_wdata,
  output logic          hb_ack,
  output logic [DW-1:0] hb_rdata,
  output logic          tbl_sel,
  input  logic [DW-1:0] tbl_rdata,
  input  logic          gsc_set,
  output logic          run,
  output logic          en,
  output logic          gts,
  output logic [DW-1:0] dma_cfg,
  output logic          irq
);

  localparam int unsigned LW = AW - 1;

  reg_sel_e      sel_e;
  logic [LW-1:0] lo_addr;
  logic          wr_hit;

  logic          run_q, en_q, gts_q, evt_q, mask_q;
  logic          run_n, en_n, gts_n, evt_n, mask_n;
  logic [DW-1:0] dma_q, dma_n;

  // ---------------- address decode ----------------
  assign lo_addr = hb_addr[LW-1:0];

  always_comb begin
    sel_e = RG_NONE;
    if (hb_addr[AW-1]) begin
      sel_e = RG_TBL;
    end else if (lo_addr == LW'(OFF_CTRL)) begin
      sel_e = RG_CTRL;
    end else if (lo_addr == LW'(OFF_DMA)) begin
      sel_e = RG_DMA;
    end else if (lo_addr == LW'(OFF_EVT)) begin
      sel_e = RG_EVT;
    end else if (lo_addr == LW'(OFF_MASK)) begin
      sel_e = RG_MASK;
    end
  end

  assign wr_hit = hb_sel & hb_wr;

  // ---------------- next state ----------------
  always_comb begin
    run_n  = run_q;
    en_n   = en_q;
    gts_n  = gts_q;
    dma_n  = dma_q;
    evt_n  = evt_q;
    mask_n = mask_q;

    if (wr_hit && sel_e == RG_CTRL) begin
      run_n = hb_wdata[CB_RUN];
      en_n  = hb_wdata[CB_EN]  & hb_wdata[CB_RUN];
      gts_n = hb_wdata[CB_GTS] & hb_wdata[CB_RUN];
    end

    if (!run_q) begin
      dma_n  = '0;
      evt_n  = 1'b0;
      mask_n = 1'b0;
    end else begin
      if (wr_hit && sel_e == RG_DMA && !en_q) begin
        dma_n = hb_wdata;
      end
      if (wr_hit && sel_e == RG_MASK) begin
        mask_n = hb_wdata[0];
      end
      if (wr_hit && sel_e == RG_EVT && hb_wdata[0]) begin
        evt_n = 1'b0;
      end
      if (gsc_set) begin
        evt_n = 1'b1;
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      en_q   <= 1'b0;
      gts_q  <= 1'b0;
      dma_q  <= '0;
      evt_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      en_q   <= en_n;
      gts_q  <= gts_n;
      dma_q  <= dma_n;
      evt_q  <= evt_n;
      mask_q <= mask_n;
    end
  end

  // ---------------- read path and acknowledge ----------------
  always_comb begin
    hb_rdata = '0;
    if (hb_sel) begin
      case (sel_e)
        RG_CTRL: begin
          hb_rdata[CB_RUN] = run_q;
          hb_rdata[CB_EN]  = en_q;
          hb_rdata[CB_GTS] = gts_q;
        end
        RG_DMA:  hb_rdata    = dma_q;
        RG_EVT:  hb_rdata[0] = evt_q;
        RG_MASK: hb_rdata[0] = mask_q;
        RG_TBL:  hb_rdata    = run_q ? tbl_rdata : '0;
        default: hb_rdata    = '0;
      endcase
    end
  end

  assign hb_ack  = hb_sel & (sel_e != RG_NONE);
  assign tbl_sel = hb_sel & (sel_e == RG_TBL) & run_q;

  assign run     = run_q;
  assign en      = en_q;
  assign gts     = gts_q;
  assign dma_cfg = dma_q;
  assign irq     = evt_q & mask_q;

  // ---------------- assertions ----------------
  // R9: the DMA word cannot move in a cycle that followed an enabled cycle
  p_dma_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q) |-> $stable(dma_q));

  // R2: a second consecutive cycle in local reset finds the gated registers clear
  p_gated_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && $past(!run_q)) |-> (dma_q == '0 && !evt_q && !mask_q));

  // R2: enable and graceful stop never stand without run
  p_ctrl_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!en_q && !gts_q));

  // R5: the event only clears through a host write of 1 or local reset
  p_evt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(evt_q) && $past(run_q)) |-> $past(wr_hit && sel_e == RG_EVT && hb_wdata[0]));

endmodule

// File: rtl/emac_stop_seq.sv
module emac_stop_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  input  logic gts,
  input  logic tx_sof,
  input  logic tx_eof,
  input  logic rx_sof,
  input  logic rx_eof,
  input  logic tx_wb_req,
  output logic tx_go,
  output logic rx_en,
  output logic tx_abort,
  output logic rx_abort,
  output logic ptr_rst,
  output logic tx_bad_crc,
  output logic tx_wb_go,
  output logic gsc_set
);

  logic en_d_q, tx_busy_q, rx_busy_q, gs_done_q, bad_crc_q;
  logic en_d_n, tx_busy_n, rx_busy_n, gs_done_n, bad_crc_n;
  logic en_fall;

  assign en_fall  = en_d_q & ~en;
  assign tx_abort = en_fall & tx_busy_q;
  assign rx_abort = en_fall & rx_busy_q;
  assign ptr_rst  = en_fall;

  assign gsc_set  = run & gts & ~tx_busy_q & ~gs_done_q;

  assign tx_go    = run & en & ~gts;
  assign rx_en    = run & en;
  assign tx_wb_go = tx_wb_req & run & en;
  assign tx_bad_crc = bad_crc_q;

  // ---------------- next state ----------------
  always_comb begin
    en_d_n    = en;
    tx_busy_n = tx_busy_q;
    rx_busy_n = rx_busy_q;

    if (tx_sof) tx_busy_n = 1'b1;
    if (tx_eof) tx_busy_n = 1'b0;
    if (rx_sof) rx_busy_n = 1'b1;
    if (rx_eof) rx_busy_n = 1'b0;

    if (!run || tx_abort) tx_busy_n = 1'b0;
    if (!run || rx_abort) rx_busy_n = 1'b0;

    gs_done_n = gts ? (gs_done_q | gsc_set) : 1'b0;
    bad_crc_n = tx_abort & run;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d_q    <= 1'b0;
      tx_busy_q <= 1'b0;
      rx_busy_q <= 1'b0;
      gs_done_q <= 1'b0;
      bad_crc_q <= 1'b0;
    end else begin
      en_d_q    <= en_d_n;
      tx_busy_q <= tx_busy_n;
      rx_busy_q <= rx_busy_n;
      gs_done_q <= gs_done_n;
      bad_crc_q <= bad_crc_n;
    end
  end

  // ---------------- assertions ----------------
  // R6: pointer reset marks every fall of enable
  p_ptr_rst_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> ptr_rst);

  // R6: abort strobes are single-cycle
  p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort || rx_abort || ptr_rst) |=> !(tx_abort || rx_abort || ptr_rst));

  // R7: a bad CRC is only ever emitted while transmission is no longer permitted
  p_badcrc_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bad_crc |-> (!tx_go && !tx_abort));

  // R4: completion is posted only while new transmit starts are withheld
  p_gsc_withheld_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gsc_set |-> !tx_go);

  // R8: descriptor write-back is never permitted in the abort cycle
  p_wb_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |-> !tx_wb_go);

endmodule

// File: rtl/emac_ctl_seq.sv
module emac_ctl_seq
  import emac_ctl_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_sel,
  input  logic          hb_wr,
  input  logic [AW-1:0] hb_addr,
  input  logic [DW-1:0] hb_wdata,
  output logic          hb_ack,
  output logic [DW-1:0] hb_rdata,
  output logic          tbl_sel,
  output logic          tbl_we,
  output logic [AW-2:0] tbl_addr,
  output logic [DW-1:0] tbl_wdata,
  input  logic [DW-1:0] tbl_rdata,
  output logic          mac_run,
  output logic          tx_go,
  output logic          rx_en,
  input  logic          tx_sof,
  input  logic          tx_eof,
  input  logic          rx_sof,
  input  logic          rx_eof,
  output logic          tx_abort,
  output logic          rx_abort,
  output logic          ptr_rst,
  output logic          tx_bad_crc,
  input  logic          tx_wb_req,
  output logic          tx_wb_go,
  output logic [DW-1:0] dma_cfg,
  output logic          irq
);

  logic srst_n;
  logic run, en, gts, gsc_set;

  emac_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  emac_host_regs #(.DW(DW), .AW(AW)) i_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .hb_sel    (hb_sel),
    .hb_wr     (hb_wr),
    .hb_addr   (hb_addr),
    .hb_wdata  (hb_wdata),
    .hb_ack    (hb_ack),
    .hb_rdata  (hb_rdata),
    .tbl_sel   (tbl_sel),
    .tbl_rdata (tbl_rdata),
    .gsc_set   (gsc_set),
    .run       (run),
    .en        (en),
    .gts       (gts),
    .dma_cfg   (dma_cfg),
    .irq       (irq)
  );

  emac_stop_seq i_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .run        (run),
    .en         (en),
    .gts        (gts),
    .tx_sof     (tx_sof),
    .tx_eof     (tx_eof),
    .rx_sof     (rx_sof),
    .rx_eof     (rx_eof),
    .tx_wb_req  (tx_wb_req),
    .tx_go      (tx_go),
    .rx_en      (rx_en),
    .tx_abort   (tx_abort),
    .rx_abort   (rx_abort),
    .ptr_rst    (ptr_rst),
    .tx_bad_crc (tx_bad_crc),
    .tx_wb_go   (tx_wb_go),
    .gsc_set    (gsc_set)
  );

  assign tbl_we    = hb_wr;
  assign tbl_addr  = hb_addr[AW-2:0];
  assign tbl_wdata = hb_wdata;
  assign mac_run   = run;

  // R11: a forwarded table strobe always carries an acknowledge and a running MAC
  p_tbl_fwd_r11: assert property (@(posedge clk) disable iff (!srst_n)
    tbl_sel |-> (hb_ack && mac_run));

endmodule

// File: tb/test_emac_ctl_seq.sv
module test_emac_ctl_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hb_sel, hb_wr;
  logic [3:0]  hb_addr;
  logic [15:0] hb_wdata;
  logic        hb_ack;
  logic [15:0] hb_rdata;
  logic        tbl_sel, tbl_we;
  logic [2:0]  tbl_addr;
  logic [15:0] tbl_wdata;
  logic [15:0] tbl_rdata;
  logic        mac_run, tx_go, rx_en;
  logic        tx_sof, tx_eof, rx_sof, rx_eof;
  logic        tx_abort, rx_abort, ptr_rst, tx_bad_crc;
  logic        tx_wb_req, tx_wb_go;
  logic [15:0] dma_cfg;
  logic        irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  emac_ctl_seq i_emac_ctl_seq (
    .clk(clk), .rst_n(rst_n),
    .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
    .hb_ack(hb_ack), .hb_rdata(hb_rdata),
    .tbl_sel(tbl_sel), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
    .mac_run(mac_run), .tx_go(tx_go), .rx_en(rx_en),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .tx_abort(tx_abort), .rx_abort(rx_abort), .ptr_rst(ptr_rst),
    .tx_bad_crc(tx_bad_crc), .tx_wb_req(tx_wb_req), .tx_wb_go(tx_wb_go),
    .dma_cfg(dma_cfg), .irq(irq)
  );

  // wr, addr, wdata, expected ack, expected read data, expected tbl_sel
  typedef struct packed {
    logic        wr;
    logic [3:0]  a;
    logic [15:0] d;
    logic        ack;
    logic [15:0] rd;
    logic        ts;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    {1'b0, 4'h0, 16'h0000, 1'b1, 16'h0000, 1'b0},  // R1 reset value
    {1'b1, 4'h0, 16'h0006, 1'b1, 16'h0000, 1'b0},  // R2 enable+gts without run
    {1'b0, 4'h0, 16'h0000, 1'b1, 16'h0000, 1'b0},  // R2 still zero
    {1'b1, 4'h1, 16'h1234, 1'b1, 16'h0000, 1'b0},  // R2 dma write in local reset
    {1'b0, 4'h1, 16'h0000, 1'b1, 16'h0000, 1'b0},  // R2 dma held zero
    {1'b1, 4'h3, 16'h0001, 1'b1, 16'h0000, 1'b0},  // R2 mask write in local reset
    {1'b0, 4'h3, 16'h0000, 1'b1, 16'h0000, 1'b0},  // R2 mask held zero
    {1'b0, 4'h9, 16'h0000, 1'b1, 16'h0000, 1'b0},  // R11 table blocked
    {1'b1, 4'h0, 16'hFFF9, 1'b1, 16'h0000, 1'b0},  // R1 run plus reserved ones
    {1'b0, 4'h0, 16'h0000, 1'b1, 16'h0001, 1'b0},  // R1 reserved read zero
    {1'b1, 4'h1, 16'h1234, 1'b1, 16'h0000, 1'b0},  // R9 write while disabled
    {1'b0, 4'h1, 16'h0000, 1'b1, 16'h1234, 1'b0},  // R9 stored
    {1'b1, 4'h0, 16'h0003, 1'b1, 16'h0000, 1'b0},  // R3 enable
    {1'b1, 4'h1, 16'hBEEF, 1'b1, 16'h0000, 1'b0},  // R9 dropped but acked
    {1'b0, 4'h1, 16'h0000, 1'b1, 16'h1234, 1'b0},  // R9 old value kept
    {1'b0, 4'h0, 16'h0000, 1'b1, 16'h0003, 1'b0},  // R1 run+enable readback
    {1'b0, 4'hA, 16'h0000, 1'b1, 16'hA5C3, 1'b1},  // R11 table forwarded
    {1'b0, 4'h5, 16'h0000, 1'b0, 16'h0000, 1'b0},  // R10 reserved read
    {1'b1, 4'h7, 16'hFFFF, 1'b0, 16'h0000, 1'b0},  // R10 reserved write
    {1'b1, 4'h3, 16'h0001, 1'b1, 16'h0000, 1'b0},  // R5 mask set
    {1'b0, 4'h3, 16'h0000, 1'b1, 16'h0001, 1'b0},  // R5 mask readback
    {1'b0, 4'h2, 16'h0000, 1'b1, 16'h0000, 1'b0}   // R5 no event yet
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [3:0] a, input logic [15:0] d,
                     output logic ack, output logic [15:0] rd, output logic ts);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = wr; hb_addr = a; hb_wdata = d;
    #1;
    ack = hb_ack; rd = hb_rdata; ts = tbl_sel;
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b0; hb_addr = '0; hb_wdata = '0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    logic ack, ts;
    logic [15:0] rd;
    bus(1'b1, a, d, ack, rd, ts);
  endtask

  task automatic rreg(input string tag, input logic [3:0] a, input logic [15:0] exp);
    logic ack, ts;
    logic [15:0] rd;
    bus(1'b0, a, 16'h0, ack, rd, ts);
    chk(tag, {15'h0, ack, rd}, {15'h0, 1'b1, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tx_sof;
    @(negedge clk); tx_sof = 1'b1; @(negedge clk); tx_sof = 1'b0;
  endtask

  task automatic pulse_tx_eof;
    @(negedge clk); tx_eof = 1'b1; @(negedge clk); tx_eof = 1'b0;
  endtask

  task automatic pulse_rx_sof;
    @(negedge clk); rx_sof = 1'b1; @(negedge clk); rx_sof = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    hb_sel = 1'b0; hb_wr = 1'b0; hb_addr = '0; hb_wdata = '0;
    tbl_rdata = 16'hA5C3;
    tx_sof = 1'b0; tx_eof = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; tx_wb_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // R1/R2/R3 reset state at the ports
    #1;
    chk("R2 mac_run after reset", mac_run, 0);
    chk("R3 tx_go after reset", tx_go, 0);
    chk("R3 rx_en after reset", rx_en, 0);
    chk("R1 dma_cfg after reset", dma_cfg, 0);
    chk("R5 irq after reset", irq, 0);

    // register vector walk
    for (int i = 0; i < NV; i++) begin
      logic ack, ts;
      logic [15:0] rd;
      bus(VEC[i].wr, VEC[i].a, VEC[i].d, ack, rd, ts);
      chk($sformatf("vec %0d ack", i), ack, VEC[i].ack);
      chk($sformatf("vec %0d tbl_sel", i), ts, VEC[i].ts);
      if (!VEC[i].wr) chk($sformatf("vec %0d rdata", i), rd, VEC[i].rd);
    end

    // R3 permissions while running and enabled
    #1;
    chk("R3 tx_go enabled", tx_go, 1);
    chk("R3 rx_en enabled", rx_en, 1);
    chk("R9 dma_cfg port", dma_cfg, 16'h1234);

    // R4 graceful stop waits for the frame in flight
    pulse_tx_sof();
    wreg(4'h0, 16'h0007);
    #1 chk("R4 tx_go withheld", tx_go, 0);
    chk("R3 rx_en kept during graceful stop", rx_en, 1);
    idle(3);
    rreg("R4 no event while busy", 4'h2, 16'h0000);
    pulse_tx_eof();
    idle(1);
    rreg("R4 event after frame end", 4'h2, 16'h0001);
    #1 chk("R5 irq with mask", irq, 1);
    idle(3);
    rreg("R5 event sticky", 4'h2, 16'h0001);
    wreg(4'h2, 16'h0001);
    rreg("R5 write one clears", 4'h2, 16'h0000);
    #1 chk("R5 irq cleared", irq, 0);
    idle(3);
    rreg("R4 posted once per request", 4'h2, 16'h0000);

    // R12 resume and re-arm
    wreg(4'h0, 16'h0003);
    #1 chk("R12 tx_go resumes", tx_go, 1);
    wreg(4'h0, 16'h0007);
    idle(2);
    rreg("R12 re-armed event idle", 4'h2, 16'h0001);
    wreg(4'h2, 16'h0001);
    wreg(4'h0, 16'h0003);
    wreg(4'h0, 16'h0007);
    idle(2);
    rreg("R12 second request posts again", 4'h2, 16'h0001);
    wreg(4'h2, 16'h0001);
    wreg(4'h0, 16'h0003);

    // R6/R7/R8 disable with frames in both directions
    pulse_tx_sof();
    pulse_rx_sof();
    tx_wb_req = 1'b1;
    #1 chk("R8 write-back allowed when enabled", tx_wb_go, 1);
    wreg(4'h0, 16'h0001);
    #1;
    chk("R6 tx_abort", tx_abort, 1);
    chk("R6 rx_abort", rx_abort, 1);
    chk("R6 ptr_rst", ptr_rst, 1);
    chk("R6 rx_en low", rx_en, 0);
    chk("R8 write-back blocked", tx_wb_go, 0);
    chk("R7 bad crc not yet", tx_bad_crc, 0);
    @(negedge clk); #1;
    chk("R7 bad crc strobe", tx_bad_crc, 1);
    chk("R6 tx_abort single", tx_abort, 0);
    chk("R6 ptr_rst single", ptr_rst, 0);
    @(negedge clk); #1;
    chk("R7 bad crc single", tx_bad_crc, 0);
    tx_wb_req = 1'b0;

    // R6/R7 disable with nothing in flight
    wreg(4'h0, 16'h0003);
    wreg(4'h0, 16'h0001);
    #1;
    chk("R6 ptr_rst idle disable", ptr_rst, 1);
    chk("R6 no tx_abort idle", tx_abort, 0);
    chk("R6 no rx_abort idle", rx_abort, 0);
    @(negedge clk); #1;
    chk("R7 no bad crc idle", tx_bad_crc, 0);

    // R7/R2 local reset abort carries no bad CRC
    wreg(4'h0, 16'h0003);
    pulse_tx_sof();
    wreg(4'h0, 16'h0000);
    #1;
    chk("R7 local reset tx_abort", tx_abort, 1);
    chk("R6 local reset ptr_rst", ptr_rst, 1);
    chk("R2 mac_run low", mac_run, 0);
    @(negedge clk); #1;
    chk("R7 no bad crc on local reset", tx_bad_crc, 0);
    idle(1);
    rreg("R2 mask cleared by local reset", 4'h3, 16'h0000);
    rreg("R2 dma cleared by local reset", 4'h1, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule